// File: doc/BRIEF.md
# Rotating-Parity Array Write Controller

This block sits between a logical block port and a striped array of five storage units. Parity is distributed: each stripe row keeps one parity block, and the unit that holds it moves by one column from row to row. Every unit therefore holds both data and parity. For each logical request the controller works out three things: the stripe row, the unit that holds the addressed data block, and the unit that holds that row's parity.

A logical read becomes a single physical read on the mapped unit. A logical write of one block becomes a read-modify-write of four accesses. The controller reads the old data and the old parity in parallel, forms the new parity, and then writes the new data and the new parity in parallel. Only one logical request is handled at a time. While `busy_o` is high, new requests are dropped. `done_o` pulses for one cycle when the request has finished.

Top module: `raid5_wr_ctrl`

## Requirements
- R1: The stripe row is the logical address divided by 4, and it is the address sent to every unit accessed. The parity column is 4 minus (row mod 5).
- R2: In a row, data blocks take the four non-parity columns in increasing logical order. Offset `addr mod 4` maps to column `offset`, or to `offset+1` when the offset is at or past the parity column.
- R3: A logical read (`we_i`=0) issues exactly one physical read, on the mapped data unit. It issues no writes. `rdata_o` holds the data returned by that unit when `done_o` pulses.
- R4: A logical write (`we_i`=1) issues exactly two physical reads (old data, old parity) and then two physical writes. No write request is raised before both reads have been acknowledged. At most two units are requested at a time.
- R5: The new data is written to the data unit. The parity unit receives old parity XOR old data XOR new data, so the XOR across the five units of that row is unchanged.
- R6: `busy_o` rises in the cycle after a request is accepted. `done_o` is high for exactly one cycle, and only after every physical access of the request has been acknowledged. `busy_o` is low in the cycle after `done_o`.
- R7: A request presented while `busy_o` is high is ignored. It causes no physical access and leaves the array unchanged.
- R8: A unit request (`unit_req_o` bit high) stays high, with stable address, write enable and write data, until that unit's one-cycle `unit_ack_i`. The data and parity acknowledgements may arrive in either order and after any latency.
- R9: After reset, `busy_o`, `done_o` and every `unit_req_o` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Logical request, accepted when `busy_o` is low |
| we_i | input | 1 | 1 = block write, 0 = block read |
| addr_i | input | LADDR_W | Logical block address |
| wdata_i | input | BLK_W | Block to write |
| busy_o | output | 1 | Request in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | BLK_W | Read result, valid with `done_o` on reads |
| unit_req_o | output | NUM_UNITS | Per-unit access request |
| unit_we_o | output | NUM_UNITS | Per-unit write enable |
| unit_addr_o | output | NUM_UNITS*LADDR_W | Per-unit row address, unit u at slice u |
| unit_wdata_o | output | NUM_UNITS*BLK_W | Per-unit write data, unit u at slice u |
| unit_ack_i | input | NUM_UNITS | Per-unit one-cycle acknowledge |
| unit_rdata_i | input | NUM_UNITS*BLK_W | Per-unit read data, valid with its acknowledge |

## Verification
A wrong parity or data column shows up on the first access to that row: the expected unit is never requested, or the wrong one is. It also shows up in the row XOR, which no longer cancels once the write finishes. A sequencer that releases the writes early is caught in the same request, when a write request appears with fewer than two reads acknowledged. A stale captured value leaves a wrong parity block that the bench checks right after `done_o`. Acknowledgement latencies are varied per unit, so that both completion orders are exercised. Requests are also injected while busy.

// File: rtl/raid5_pkg.sv
package raid5_pkg;
  localparam int unsigned DEF_UNITS   = 5;
  localparam int unsigned DEF_BLK_W   = 32;
  localparam int unsigned DEF_LADDR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,   // single read of a logical read
    ST_RDS,   // old data + old parity reads
    ST_CALC,  // parity update
    ST_WRS,   // new data + new parity writes
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/raid5_map.sv
module raid5_map #(
  parameter int unsigned NUM_UNITS = 5,
  parameter int unsigned LADDR_W   = 16,
  localparam int unsigned DPR      = NUM_UNITS - 1,
  localparam int unsigned COL_W    = $clog2(NUM_UNITS)
) (
  input  logic [LADDR_W-1:0] addr_i,
  output logic [LADDR_W-1:0] row_o,
  output logic [COL_W-1:0]   dcol_o,
  output logic [COL_W-1:0]   pcol_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_UNITS - 1);

  logic [LADDR_W-1:0] off_full, rmod_full;
  logic [COL_W-1:0]   off;

  assign row_o     = addr_i / LADDR_W'(DPR);
  assign off_full  = addr_i % LADDR_W'(DPR);
  assign rmod_full = row_o % LADDR_W'(NUM_UNITS);
  assign off       = off_full[COL_W-1:0];
  assign pcol_o    = LAST_COL - rmod_full[COL_W-1:0];
  // skip over the parity column
  assign dcol_o    = (off >= pcol_o) ? off + COL_W'(1) : off;
endmodule

// File: rtl/raid5_seq.sv
module raid5_seq
  import raid5_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 5,
  parameter int unsigned BLK_W     = 32,
  parameter int unsigned LADDR_W   = 16,
  localparam int unsigned COL_W    = $clog2(NUM_UNITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [BLK_W-1:0]   wdata_i,
  input  logic [LADDR_W-1:0] map_row_i,
  input  logic [COL_W-1:0]   map_dcol_i,
  input  logic [COL_W-1:0]   map_pcol_i,
  input  logic               data_ack_i,
  input  logic               par_ack_i,
  input  logic [BLK_W-1:0]   data_rdata_i,
  input  logic [BLK_W-1:0]   par_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [BLK_W-1:0]   rdata_o,
  output logic               data_req_o,
  output logic               par_req_o,
  output logic               wr_o,
  output logic [LADDR_W-1:0] row_o,
  output logic [COL_W-1:0]   dcol_o,
  output logic [COL_W-1:0]   pcol_o,
  output logic [BLK_W-1:0]   new_data_o,
  output logic [BLK_W-1:0]   new_par_o
);
  seq_state_e state_q, state_d;
  logic d_ok_q, p_ok_q, d_done, p_done;
  logic [BLK_W-1:0] old_d_q, old_p_q;

  assign d_done = d_ok_q | data_ack_i;
  assign p_done = p_ok_q | par_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = we_i ? ST_RDS : ST_RD1;
      ST_RD1:  if (data_ack_i) state_d = ST_DONE;
      ST_RDS:  if (d_done && p_done) state_d = ST_CALC;
      ST_CALC: state_d = ST_WRS;
      ST_WRS:  if (d_done && p_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      d_ok_q     <= 1'b0;
      p_ok_q     <= 1'b0;
      old_d_q    <= '0;
      old_p_q    <= '0;
      row_o      <= '0;
      dcol_o     <= '0;
      pcol_o     <= '0;
      new_data_o <= '0;
      new_par_o  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        row_o      <= map_row_i;
        dcol_o     <= map_dcol_i;
        pcol_o     <= map_pcol_i;
        new_data_o <= wdata_i;
        d_ok_q     <= 1'b0;
        p_ok_q     <= 1'b0;
      end else if (state_q == ST_CALC) begin
        new_par_o <= old_p_q ^ old_d_q ^ new_data_o;
        d_ok_q    <= 1'b0;
        p_ok_q    <= 1'b0;
      end else begin
        if (data_ack_i) d_ok_q <= 1'b1;
        if (par_ack_i)  p_ok_q <= 1'b1;
      end
      if ((state_q == ST_RD1 || state_q == ST_RDS) && data_ack_i) old_d_q <= data_rdata_i;
      if (state_q == ST_RDS && par_ack_i) old_p_q <= par_rdata_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign rdata_o    = old_d_q;
  assign wr_o       = (state_q == ST_WRS);
  assign data_req_o = (state_q == ST_RD1 || state_q == ST_RDS || state_q == ST_WRS) && !d_ok_q;
  assign par_req_o  = (state_q == ST_RDS || state_q == ST_WRS) && !p_ok_q;

  // R4
  wr_after_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_o) |-> $past(state_q == ST_CALC));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R6
  done_after_acks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(data_ack_i || par_ack_i));
  // R7
  hold_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(row_o) && $stable(dcol_o) && $stable(new_data_o));
endmodule

// File: rtl/raid5_unit_if.sv
module raid5_unit_if #(
  parameter int unsigned NUM_UNITS = 5,
  parameter int unsigned BLK_W     = 32,
  parameter int unsigned LADDR_W   = 16,
  parameter int unsigned UNIT_IDX  = 0,
  localparam int unsigned COL_W    = $clog2(NUM_UNITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_i,
  input  logic               data_req_i,
  input  logic               par_req_i,
  input  logic               wr_i,
  input  logic [COL_W-1:0]   dcol_i,
  input  logic [COL_W-1:0]   pcol_i,
  input  logic [LADDR_W-1:0] row_i,
  input  logic [BLK_W-1:0]   data_wdata_i,
  input  logic [BLK_W-1:0]   par_wdata_i,
  output logic               req_o,
  output logic               we_o,
  output logic [LADDR_W-1:0] addr_o,
  output logic [BLK_W-1:0]   wdata_o
);
  localparam logic [COL_W-1:0] MY_COL = COL_W'(UNIT_IDX);

  logic is_data, is_par;
  assign is_data = (dcol_i == MY_COL);
  assign is_par  = (pcol_i == MY_COL);
  assign req_o   = (data_req_i && is_data) || (par_req_i && is_par);
  assign we_o    = wr_i && req_o;
  assign addr_o  = row_i;
  assign wdata_o = is_data ? data_wdata_i : par_wdata_i;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));
endmodule

// File: rtl/raid5_wr_ctrl.sv
module raid5_wr_ctrl
  import raid5_pkg::*;
#(
  parameter int unsigned NUM_UNITS = DEF_UNITS,
  parameter int unsigned BLK_W     = DEF_BLK_W,
  parameter int unsigned LADDR_W   = DEF_LADDR_W,
  localparam int unsigned COL_W    = $clog2(NUM_UNITS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [LADDR_W-1:0]           addr_i,
  input  logic [BLK_W-1:0]             wdata_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [BLK_W-1:0]             rdata_o,
  output logic [NUM_UNITS-1:0]         unit_req_o,
  output logic [NUM_UNITS-1:0]         unit_we_o,
  output logic [NUM_UNITS*LADDR_W-1:0] unit_addr_o,
  output logic [NUM_UNITS*BLK_W-1:0]   unit_wdata_o,
  input  logic [NUM_UNITS-1:0]         unit_ack_i,
  input  logic [NUM_UNITS*BLK_W-1:0]   unit_rdata_i
);
  logic [LADDR_W-1:0] map_row, s_row;
  logic [COL_W-1:0]   map_dcol, map_pcol, s_dcol, s_pcol;
  logic               data_req, par_req, wr;
  logic [BLK_W-1:0]   new_data, new_par;
  logic [BLK_W-1:0]   rd_arr [NUM_UNITS];
  logic               accept;

  assign accept = req_i && !busy_o;

  raid5_map #(.NUM_UNITS(NUM_UNITS), .LADDR_W(LADDR_W)) u_map (
    .addr_i (addr_i),
    .row_o  (map_row),
    .dcol_o (map_dcol),
    .pcol_o (map_pcol)
  );

  raid5_seq #(.NUM_UNITS(NUM_UNITS), .BLK_W(BLK_W), .LADDR_W(LADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .wdata_i      (wdata_i),
    .map_row_i    (map_row),
    .map_dcol_i   (map_dcol),
    .map_pcol_i   (map_pcol),
    .data_ack_i   (unit_ack_i[s_dcol]),
    .par_ack_i    (unit_ack_i[s_pcol]),
    .data_rdata_i (rd_arr[s_dcol]),
    .par_rdata_i  (rd_arr[s_pcol]),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .data_req_o   (data_req),
    .par_req_o    (par_req),
    .wr_o         (wr),
    .row_o        (s_row),
    .dcol_o       (s_dcol),
    .pcol_o       (s_pcol),
    .new_data_o   (new_data),
    .new_par_o    (new_par)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign rd_arr[u] = unit_rdata_i[u*BLK_W +: BLK_W];
    raid5_unit_if #(
      .NUM_UNITS(NUM_UNITS), .BLK_W(BLK_W), .LADDR_W(LADDR_W), .UNIT_IDX(u)
    ) u_if (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ack_i        (unit_ack_i[u]),
      .data_req_i   (data_req),
      .par_req_i    (par_req),
      .wr_i         (wr),
      .dcol_i       (s_dcol),
      .pcol_i       (s_pcol),
      .row_i        (s_row),
      .data_wdata_i (new_data),
      .par_wdata_i  (new_par),
      .req_o        (unit_req_o[u]),
      .we_o         (unit_we_o[u]),
      .addr_o       (unit_addr_o[u*LADDR_W +: LADDR_W]),
      .wdata_o      (unit_wdata_o[u*BLK_W +: BLK_W])
    );
  end

  // R2
  map_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (map_dcol != map_pcol) && (map_dcol < COL_W'(NUM_UNITS))
               && (map_pcol < COL_W'(NUM_UNITS)));
  // R4
  req_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(unit_req_o) <= 2);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (unit_req_o == '0));
endmodule

// File: tb/raid5_wr_ctrl_bench.sv
module raid5_wr_ctrl_bench;
  localparam int NU = 5;
  localparam int BW = 32;
  localparam int AW = 16;
  localparam int ROWS = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] wdata = '0;
  logic busy, done;
  logic [BW-1:0] rdata;
  logic [NU-1:0] u_req, u_we, u_ack;
  logic [NU*AW-1:0] u_addr;
  logic [NU*BW-1:0] u_wdata, u_rdata;
  logic [BW-1:0] rd_q [NU];

  int n_chk = 0, n_fail = 0;
  int lat [NU];
  int cnt [NU];
  int rd_cnt = 0, wr_cnt = 0, rd_unit = -1, order_err = 0, stable_err = 0;
  logic [BW-1:0] mem [NU][ROWS];
  logic pend_q [NU];
  logic [AW-1:0] paddr_q [NU];
  logic [BW-1:0] pwdata_q [NU];
  logic pwe_q [NU];
  bit finished = 0;

  always #10 clk = ~clk;

  raid5_wr_ctrl u_raid5_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .unit_req_o(u_req), .unit_we_o(u_we), .unit_addr_o(u_addr),
    .unit_wdata_o(u_wdata), .unit_ack_i(u_ack), .unit_rdata_i(u_rdata)
  );

  always_comb for (int u = 0; u < NU; u++) u_rdata[u*BW +: BW] = rd_q[u];

  // unit models: fixed latency per unit, one-cycle ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        u_ack[u] <= 1'b0; rd_q[u] <= '0; cnt[u] = 0; pend_q[u] = 1'b0;
      end
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (pend_q[u] && (!u_req[u] || u_addr[u*AW +: AW] != paddr_q[u] ||
            u_we[u] != pwe_q[u] || u_wdata[u*BW +: BW] != pwdata_q[u]))
          stable_err++;
        pend_q[u]   = u_req[u] && !u_ack[u];
        paddr_q[u]  = u_addr[u*AW +: AW];
        pwe_q[u]    = u_we[u];
        pwdata_q[u] = u_wdata[u*BW +: BW];
        if (u_req[u] && !u_ack[u]) begin
          if (u_we[u] && rd_cnt < 2) order_err++;
          if (cnt[u] >= lat[u]) begin
            cnt[u] = 0;
            u_ack[u] <= 1'b1;
            rd_q[u]  <= mem[u][u_addr[u*AW +: 5]];
            if (u_we[u]) begin
              mem[u][u_addr[u*AW +: 5]] = u_wdata[u*BW +: BW];
              wr_cnt++;
            end else begin
              rd_cnt++; rd_unit = u;
            end
          end else cnt[u]++;
        end else u_ack[u] <= 1'b0;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_map(int a, output int r, output int dc, output int pc);
    int off, n;
    r = a / 4; off = a % 4; pc = 4;
    for (int k = 0; k < r; k++) pc = (pc == 0) ? 4 : pc - 1;
    dc = -1; n = 0;
    for (int c = 0; c < NU; c++) if (c != pc) begin
      if (n == off) dc = c;
      n++;
    end
  endfunction

  function automatic logic [BW-1:0] row_xor(int r);
    logic [BW-1:0] x = '0;
    for (int u = 0; u < NU; u++) x ^= mem[u][r];
    return x;
  endfunction

  task automatic set_lat(int a0, int a1, int a2, int a3, int a4);
    lat[0] = a0; lat[1] = a1; lat[2] = a2; lat[3] = a3; lat[4] = a4;
  endtask

  // issue one request and wait for done; optional intruder while busy
  task automatic run_op(bit w, int a, logic [BW-1:0] d, bit intrude, int ia);
    int t;
    rd_cnt = 0; wr_cnt = 0; rd_unit = -1; order_err = 0; stable_err = 0;
    @(negedge clk);
    req = 1; we = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 0;
    chk(busy === 1'b1 && done === 1'b0, "R6 busy after accept", {30'b0, busy, done}, 32'h2);
    if (intrude) begin
      req = 1; we = 1; addr = AW'(ia); wdata = 32'hdead_beef;
      @(negedge clk);
      req = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 500) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R6 done seen", {31'b0, done}, 32'h1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R6 done one cycle then idle", {30'b0, busy, done}, 32'h0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0 && u_req === '0, "R9 reset outputs",
        {25'b0, u_req, busy, done}, 32'h0);
  endtask

  task automatic t_read(int a);
    int r, dc, pc;
    exp_map(a, r, dc, pc);
    run_op(0, a, '0, 0, 0);
    chk(rdata === mem[dc][r], "R3 read data", rdata, mem[dc][r]);
    chk(rd_cnt == 1 && wr_cnt == 0, "R3 one read only", rd_cnt * 16 + wr_cnt, 32'h10);
    chk(rd_unit == dc, "R2 read unit", rd_unit, dc);
    after_done();
  endtask

  task automatic t_write(int a, logic [BW-1:0] d, bit intrude, int ia);
    int r, dc, pc, ir, idc, ipc;
    logic [BW-1:0] od, op, snap [NU];
    exp_map(a, r, dc, pc);
    exp_map(ia, ir, idc, ipc);
    od = mem[dc][r]; op = mem[pc][r];
    for (int u = 0; u < NU; u++) snap[u] = mem[u][r];
    run_op(1, a, d, intrude, ia);
    chk(mem[dc][r] === d, "R2 data unit written", mem[dc][r], d);
    chk(mem[pc][r] === (op ^ od ^ d), "R5 parity update", mem[pc][r], op ^ od ^ d);
    chk(row_xor(r) === '0, "R5 row xor", row_xor(r), 32'h0);
    chk(rd_cnt == 2 && wr_cnt == 2, "R4 access counts", rd_cnt * 16 + wr_cnt, 32'h22);
    chk(order_err == 0, "R4 writes after reads", order_err, 0);
    chk(stable_err == 0, "R8 request held stable", stable_err, 0);
    for (int u = 0; u < NU; u++)
      if (u != dc && u != pc)
        chk(mem[u][r] === snap[u], "R1 other units untouched", mem[u][r], snap[u]);
    if (intrude)
      chk(mem[idc][ir] !== 32'hdead_beef, "R7 busy request ignored", mem[idc][ir], 32'h0);
    after_done();
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int u = 0; u < NU; u++) mem[u][r] = 32'h1000_0000 * u + 32'h0101 * r + 32'h37;
      mem[NU-1][r] = '0;
      mem[NU-1][r] = row_xor(r);
    end
    set_lat(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    // R1 R2 reads over rotating rows
    t_read(0);
    t_read(7);
    set_lat(3, 1, 0, 2, 4);
    t_read(19);
    t_read(45);
    // R5 writes, data ack before parity ack and the reverse (R8)
    set_lat(0, 0, 0, 0, 5);
    t_write(3, 32'ha5a5_0001, 0, 0);
    set_lat(6, 0, 2, 0, 0);
    t_write(4, 32'h0bad_f00d, 0, 0);
    t_write(7, 32'h1234_5678, 0, 0);
    set_lat(1, 4, 0, 3, 2);
    t_write(16, 32'hffff_0000, 0, 0);
    t_write(22, 32'h0000_ffff, 0, 0);
    t_write(45, 32'hcafe_1234, 0, 0);
    // R7 intruder while busy
    set_lat(2, 2, 2, 2, 2);
    t_write(9, 32'h5555_aaaa, 1, 30);
    t_read(30);
    // back-to-back write then read same block (R3)
    t_write(22, 32'h7777_1111, 0, 0);
    t_read(22);
    chk(rdata === 32'h7777_1111, "R3 read after write", rdata, 32'h7777_1111);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule